// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is a general-purpose up-counting timer with up to four compare channels that produce pulse-width modulated waveforms. A prescaler divides the input clock. A counter runs from zero up to a programmed period. Each channel compares the counter against its own compare value to decide whether its pin is active. Two counting schemes are available: edge-aligned, where the counter wraps to zero, and center-aligned, where it climbs to the period and then descends.

Software programs the block through a simple single-cycle write port. The prescaler, period and compare values are double-buffered. A write lands in a holding copy. The working copy only changes on an update event, which is either the end of a counting cycle or a software-forced update. The period and each compare value can instead be made to take effect at once by turning their buffering off. Every update event raises a sticky flag. A one-pulse mode stops the counter after one cycle. A main output gate holds every pin low until software opens it.

Write addresses are: 0 control, 1 prescaler, 2 period, 3 force update, 4 flag clear, 8+n compare value of channel n, 12+n configuration of channel n. Control bits are: bit0 count enable, bit1 period buffering, bit2 one-pulse, bit3 center-aligned, bit4 main output gate. Channel configuration bits are: [2:0] output mode, bit3 polarity, bit4 pin enable, bit5 compare buffering.

Top module: `pwm_timer`

## Requirements
- R1: With count enable (control bit0) set, the counter advances once every prescaler+1 clocks. In edge-aligned mode it runs 0, 1, … up to the active period and then returns to 0. With count enable clear it holds its value.
- R2: The update flag is set by every update event. Writing address 4 with bit0 = 1 clears it. A set in the same cycle wins over the clear.
- R3: Output mode 3'b110 makes the channel active while counter < compare. Output mode 3'b111 makes it active while counter >= compare.
- R4: In mode 3'b110, a compare value above the period keeps the channel active for the whole period. A compare value of 0 keeps it inactive.
- R5: With compare buffering (configuration bit5) set, a new compare value reaches the active compare only on an update event. With it clear, the new value applies from the next clock.
- R6: With period buffering (control bit1) set, a new period reaches the active period only on an update event. With it clear, the new value applies from the next clock.
- R7: A prescaler write always waits for an update event before it changes the division ratio.
- R8: A write to address 3 forces an update event. It loads every buffered value, resets the counter and prescaler to 0, and sets the update flag.
- R9: Polarity bit 1 inverts the channel's active level. Pin enable bit 0 forces that pin to 0.
- R10: While the main output gate (control bit4) is 0, every pin drives 0.
- R11: In center-aligned mode (control bit3) the counter rises to the period and then falls back to 0. A counter update event occurs only when the falling count reaches 0.
- R12: In one-pulse mode (control bit2), count enable clears itself at the next counter update event, leaving the counter at 0.
- R13: Output mode 3'b101 forces the channel active. Any mode other than 3'b101, 3'b110 and 3'b111 forces it inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 4 | Write address |
| wr_data | input | DW (16) | Write data |
| pwm_out | output | NCH (4) | Channel pins |
| upd_flag | output | 1 | Sticky update flag |
| cnt_val | output | CNT_W (16) | Current counter value |

## Verification
A wrong internal state shows up at the ports within one counting period. A corrupted working period or compare value moves the pin edges or the wrap point. A prescaler loaded early or late changes how many clocks each count lasts. A missed or spurious update event shows on the flag in the next cycle. The bench therefore mirrors the whole block in a behavioural model and compares the counter, the flag and every pin on every clock. This exposes a divergence in the very cycle it first reaches a port, rather than at the end of a scenario.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int ADDR_W = 4;

    // write-port address map
    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_PSC     = 4'd1;
    localparam logic [ADDR_W-1:0] A_PER     = 4'd2;
    localparam logic [ADDR_W-1:0] A_FORCE   = 4'd3;
    localparam logic [ADDR_W-1:0] A_FLAGCLR = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMP0    = 4'd8;
    localparam logic [ADDR_W-1:0] A_CFG0    = 4'd12;

    // channel output mode codes
    localparam logic [2:0] OM_FORCE_ON = 3'b101;
    localparam logic [2:0] OM_BELOW    = 3'b110;
    localparam logic [2:0] OM_ABOVE    = 3'b111;

    typedef struct packed {
        logic gate;     // bit4 main output gate
        logic center;   // bit3 center-aligned counting
        logic single;   // bit2 one-pulse
        logic per_buf;  // bit1 period buffering
        logic run;      // bit0 count enable
    } ctrl_t;

    typedef struct packed {
        logic       cmp_buf; // bit5
        logic       pin_en;  // bit4
        logic       inv;     // bit3
        logic [2:0] mode;    // bits 2:0
    } chcfg_t;

    typedef enum logic { PH_RISE = 1'b0, PH_FALL = 1'b1 } phase_e;

endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int NCH   = 4,
    parameter int DW    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic                      uev,
    input  logic                      single_stop,
    output ctrl_t                     ctrl,
    output logic [PSC_W-1:0]          psc_act,
    output logic [CNT_W-1:0]          per_act,
    output logic [NCH-1:0][CNT_W-1:0] cmp_act,
    output chcfg_t [NCH-1:0]          cfg,
    output logic                      flag
);

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int CFG_W  = $bits(chcfg_t);

    typedef struct packed {
        ctrl_t                     ctrl;
        logic [PSC_W-1:0]          psc_hold;
        logic [PSC_W-1:0]          psc_act;
        logic [CNT_W-1:0]          per_hold;
        logic [CNT_W-1:0]          per_act;
        logic [NCH-1:0][CNT_W-1:0] cmp_hold;
        logic [NCH-1:0][CNT_W-1:0] cmp_act;
        chcfg_t [NCH-1:0]          cfg;
        logic                      flag;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == A_CTRL)
                r_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_addr == A_PSC)
                r_d.psc_hold = wr_data[PSC_W-1:0];
            if (wr_addr == A_PER) begin
                r_d.per_hold = wr_data[CNT_W-1:0];
                if (!r_q.ctrl.per_buf)
                    r_d.per_act = wr_data[CNT_W-1:0];
            end
            if (wr_addr == A_FLAGCLR && wr_data[0])
                r_d.flag = 1'b0;
        end
        for (int ch = 0; ch < NCH; ch++) begin
            if (wr_en && wr_addr == (A_CMP0 + ADDR_W'(ch))) begin
                r_d.cmp_hold[ch] = wr_data[CNT_W-1:0];
                if (!r_q.cfg[ch].cmp_buf)
                    r_d.cmp_act[ch] = wr_data[CNT_W-1:0];
            end
            if (wr_en && wr_addr == (A_CFG0 + ADDR_W'(ch)))
                r_d.cfg[ch] = chcfg_t'(wr_data[CFG_W-1:0]);
        end
        if (single_stop)
            r_d.ctrl.run = 1'b0;
        // update event: copy holding values (including a same-cycle write)
        if (uev) begin
            r_d.psc_act = r_d.psc_hold;
            r_d.per_act = r_d.per_hold;
            for (int ch = 0; ch < NCH; ch++)
                r_d.cmp_act[ch] = r_d.cmp_hold[ch];
            r_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl    = r_q.ctrl;
    assign psc_act = r_q.psc_act;
    assign per_act = r_q.per_act;
    assign cmp_act = r_q.cmp_act;
    assign cfg     = r_q.cfg;
    assign flag    = r_q.flag;

endmodule

// File: rtl/pwm_timer_count.sv
module pwm_timer_count
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             center,
    input  logic             single,
    input  logic             force_upd,
    input  logic [PSC_W-1:0] psc_act,
    input  logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_uev,
    output logic             single_stop
);

    typedef struct packed {
        logic [PSC_W-1:0] div;
        logic [CNT_W-1:0] cnt;
        phase_e           phase;
    } cnt_t;

    cnt_t c_d, c_q;
    logic tick;

    always_comb begin
        c_d     = c_q;
        tick    = 1'b0;
        cnt_uev = 1'b0;
        if (run) begin
            if (c_q.div >= psc_act) begin
                c_d.div = '0;
                tick    = 1'b1;
            end else begin
                c_d.div = c_q.div + 1'b1;
            end
        end
        if (tick) begin
            if (!center) begin
                c_d.phase = PH_RISE;
                if (c_q.cnt >= per_act) begin
                    c_d.cnt = '0;
                    cnt_uev = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end else if (c_q.phase == PH_RISE) begin
                if (c_q.cnt >= per_act) begin
                    if (per_act == '0) begin
                        c_d.cnt = '0;
                        cnt_uev = 1'b1;
                    end else begin
                        c_d.cnt   = c_q.cnt - 1'b1;
                        c_d.phase = PH_FALL;
                    end
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end else begin
                if (c_q.cnt <= CNT_W'(1)) begin
                    c_d.cnt   = '0;
                    c_d.phase = PH_RISE;
                    cnt_uev   = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
        end
        if (force_upd) begin
            c_d     = '0;
            cnt_uev = 1'b0;
        end
        single_stop = cnt_uev & single;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  chcfg_t           cfg,
    input  logic             gate,
    output logic             pin
);

    logic below;
    logic active;

    always_comb begin
        below = (cnt < cmp);
        unique case (cfg.mode)
            OM_BELOW:    active = below;
            OM_ABOVE:    active = ~below;
            OM_FORCE_ON: active = 1'b1;
            default:     active = 1'b0;
        endcase
        pin = (gate && cfg.pin_en) ? (active ^ cfg.inv) : 1'b0;
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int NCH   = 4,
    parameter int DW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NCH-1:0]    pwm_out,
    output logic              upd_flag,
    output logic [CNT_W-1:0]  cnt_val
);

    ctrl_t                     ctrl;
    logic [PSC_W-1:0]          psc_act;
    logic [CNT_W-1:0]          per_act;
    logic [NCH-1:0][CNT_W-1:0] cmp_act;
    chcfg_t [NCH-1:0]          cfg;
    logic                      force_upd;
    logic                      cnt_uev;
    logic                      single_stop;
    logic                      uev;
    logic                      run_q;
    logic                      single_q;
    logic                      gate_q;
    logic                      per_buf_q;

    assign force_upd = wr_en && (wr_addr == A_FORCE);
    assign uev       = force_upd | cnt_uev;
    assign run_q     = ctrl.run;
    assign single_q  = ctrl.single;
    assign gate_q    = ctrl.gate;
    assign per_buf_q = ctrl.per_buf;

    pwm_timer_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .NCH(NCH), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .uev         (uev),
        .single_stop (single_stop),
        .ctrl        (ctrl),
        .psc_act     (psc_act),
        .per_act     (per_act),
        .cmp_act     (cmp_act),
        .cfg         (cfg),
        .flag        (upd_flag)
    );

    pwm_timer_count #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (ctrl.run),
        .center      (ctrl.center),
        .single      (ctrl.single),
        .force_upd   (force_upd),
        .psc_act     (psc_act),
        .per_act     (per_act),
        .cnt         (cnt_val),
        .cnt_uev     (cnt_uev),
        .single_stop (single_stop)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pwm_timer_chan #(.CNT_W(CNT_W)) u_chan (
            .cnt  (cnt_val),
            .cmp  (cmp_act[ch]),
            .cfg  (cfg[ch]),
            .gate (ctrl.gate),
            .pin  (pwm_out[ch])
        );
    end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int CNT_W = 16,
    parameter int NCH   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       wr_addr,
    input logic             wr_bit0,
    input logic             force_upd,
    input logic             cnt_uev,
    input logic             uev,
    input logic             run,
    input logic             single,
    input logic             gate,
    input logic             per_buf,
    input logic [CNT_W-1:0] per_act,
    input logic [CNT_W-1:0] cnt_val,
    input logic             upd_flag,
    input logic [NCH-1:0]   pwm_out
);

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd4 && wr_bit0 && !uev) |=> !upd_flag); // R2

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        uev |=> upd_flag); // R2

    AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> (pwm_out == '0)); // R10

    AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_uev && single) |=> !run); // R12

    AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (cnt_val == '0 && upd_flag)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !force_upd) |=> $stable(cnt_val)); // R1

    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (per_buf && !uev) |=> $stable(per_act)); // R6

endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_bit0   (wr_data[0]),
    .force_upd (force_upd),
    .cnt_uev   (cnt_uev),
    .uev       (uev),
    .run       (run_q),
    .single    (single_q),
    .gate      (gate_q),
    .per_buf   (per_buf_q),
    .per_act   (per_act),
    .cnt_val   (cnt_val),
    .upd_flag  (upd_flag),
    .pwm_out   (pwm_out)
);

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [NCH-1:0] pwm_out;
    logic        upd_flag;
    logic [15:0] cnt_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    pwm_timer u_pwm_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .upd_flag(upd_flag), .cnt_val(cnt_val)
    );

    // behavioural reference model
    bit m_run, m_perbuf, m_single, m_center, m_gate, m_flag, m_fall;
    int m_psc_h, m_psc_a, m_per_h, m_per_a, m_div, m_cnt;
    int m_cmp_h[NCH], m_cmp_a[NCH], m_mode[NCH];
    bit m_inv[NCH], m_en[NCH], m_cbuf[NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_run, m_perbuf, m_single, m_center, m_gate, m_flag, m_fall} = '0;
            m_psc_h = 0; m_psc_a = 0; m_per_h = 0; m_per_a = 0; m_div = 0; m_cnt = 0;
            for (int i = 0; i < NCH; i++) begin
                m_cmp_h[i] = 0; m_cmp_a[i] = 0; m_mode[i] = 0;
                m_inv[i] = 0; m_en[i] = 0; m_cbuf[i] = 0;
            end
        end else begin
            bit frc, step, wrapped;
            frc = wr_en && wr_addr == 4'd3;
            step = 0; wrapped = 0;
            if (m_run) begin
                if (m_div >= m_psc_a) begin m_div = 0; step = 1; end
                else m_div++;
            end
            if (step) begin
                if (!m_center) begin
                    m_fall = 0;
                    if (m_cnt >= m_per_a) begin m_cnt = 0; wrapped = 1; end
                    else m_cnt++;
                end else if (!m_fall) begin
                    if (m_cnt < m_per_a) m_cnt++;
                    else if (m_per_a == 0) begin m_cnt = 0; wrapped = 1; end
                    else begin m_cnt--; m_fall = 1; end
                end else begin
                    if (m_cnt > 1) m_cnt--;
                    else begin m_cnt = 0; m_fall = 0; wrapped = 1; end
                end
            end
            if (frc) begin m_div = 0; m_cnt = 0; m_fall = 0; wrapped = 0; end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: {m_gate, m_center, m_single, m_perbuf, m_run} = wr_data[4:0];
                    4'd1: m_psc_h = wr_data;
                    4'd2: begin m_per_h = wr_data; if (!m_perbuf) m_per_a = wr_data; end
                    4'd4: if (wr_data[0]) m_flag = 0;
                    default: ;
                endcase
                for (int i = 0; i < NCH; i++) begin
                    if (wr_addr == 4'(8 + i)) begin
                        m_cmp_h[i] = wr_data;
                        if (!m_cbuf[i]) m_cmp_a[i] = wr_data;
                    end
                    if (wr_addr == 4'(12 + i)) begin
                        m_mode[i] = wr_data[2:0]; m_inv[i] = wr_data[3];
                        m_en[i] = wr_data[4]; m_cbuf[i] = wr_data[5];
                    end
                end
            end
            if (wrapped && m_single) m_run = 0;
            if (wrapped || frc) begin
                m_psc_a = m_psc_h; m_per_a = m_per_h; m_flag = 1;
                for (int i = 0; i < NCH; i++) m_cmp_a[i] = m_cmp_h[i];
            end
        end
    end

    function automatic logic [NCH-1:0] model_pins();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) begin
            bit act;
            case (m_mode[i])
                6: act = (m_cnt < m_cmp_a[i]);
                7: act = !(m_cnt < m_cmp_a[i]);
                5: act = 1;
                default: act = 0;
            endcase
            v[i] = (m_gate && m_en[i]) ? (act ^ m_inv[i]) : 1'b0;
        end
        return v;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1", "counter", int'(cnt_val), m_cnt);
            chk("R2", "flag", int'(upd_flag), int'(m_flag));
            chk(tag, "pins", int'(pwm_out), int'(model_pins()));
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // reset state
        chk("R1", "reset counter", int'(cnt_val), 0);
        chk("R2", "reset flag", int'(upd_flag), 0);
        chk("R10", "reset pins", int'(pwm_out), 0);

        // R3 / R13: mixed modes, edge-aligned
        tag = "R3";
        wr(12, 6 | 16); wr(13, 7 | 16); wr(14, 6 | 8 | 16); wr(15, 5 | 16);
        wr(8, 3); wr(9, 3); wr(10, 5); wr(11, 2);
        wr(1, 0); wr(2, 9); wr(3, 0);
        wr(0, 5'h11);
        idle(35);
        tag = "R13";
        wr(15, 4 | 16); idle(6); wr(15, 0 | 16); idle(6); wr(15, 5 | 16); idle(6);

        // R7: buffered prescaler
        tag = "R7";
        wr(1, 2); idle(50);

        // R5: buffered vs direct compare
        tag = "R5";
        wr(12, 6 | 16 | 32); wr(8, 7); idle(4); wr(9, 8); idle(60);

        // R6: buffered period
        tag = "R6";
        wr(0, 5'h13); wr(2, 5); idle(70); wr(0, 5'h11); wr(2, 4); idle(30);

        // R9: polarity and pin enable
        tag = "R9";
        wr(13, 7 | 8 | 16); idle(20); wr(14, 6); idle(20);

        // R2 / R8: flag clear and forced update with stopped counter
        tag = "R8";
        wr(0, 5'h10);
        wr(4, 1);
        chk("R2", "flag after clear", int'(upd_flag), 0);
        wr(1, 0); wr(3, 0);
        chk("R8", "counter after force", int'(cnt_val), 0);
        chk("R8", "flag after force", int'(upd_flag), 1);

        // R4: compare above period and compare zero
        tag = "R4";
        wr(2, 7); wr(12, 6 | 16); wr(8, 20); wr(13, 6 | 16); wr(9, 0);
        wr(3, 0); wr(0, 5'h11);
        for (int k = 0; k < 20; k++) begin
            idle(1);
            chk("R4", "cmp>period pin", int'(pwm_out[0]), 1);
            chk("R4", "cmp=0 pin", int'(pwm_out[1]), 0);
        end

        // R11: center-aligned counting
        tag = "R11";
        wr(8, 3); wr(9, 5); wr(0, 5'h19); idle(45);
        wr(1, 1); wr(3, 0); idle(45);

        // R12: one-pulse
        tag = "R12";
        wr(0, 5'h10); wr(1, 0); wr(2, 7); wr(3, 0); wr(0, 5'h15);
        idle(30);
        chk("R12", "counter stopped", int'(cnt_val), 0);
        idle(5);
        chk("R12", "counter still stopped", int'(cnt_val), 0);

        // R10: main gate closed while running
        tag = "R10";
        wr(0, 5'h01); idle(1);
        for (int k = 0; k < 12; k++) begin
            idle(1);
            chk("R10", "gated pins", int'(pwm_out), 0);
        end
        wr(0, 5'h11); idle(20);

        finish_run();
    end

endmodule